// File: doc/BRIEF.md
# Programmable Triple Clock Divider

This block turns one root clock into three clock-enable streams: one for the bus domain, one for the peripheral domain and one for an auxiliary domain. A single 32-bit control word holds a separate divide field for each stream. Each enable pulses once per divided period, so logic clocked by the root clock and qualified by an enable runs at the divided rate.

The control word is reached through a small synchronous register port with a request, a write strobe, an address and a combinational read path. Software may rewrite the word at any moment. Each field is kept exactly as written. A clamp then maps it onto the legal divide range, where a value above the maximum acts as the maximum and zero acts as one. Each divider takes a new ratio only when its count wraps. The period that is running when a write arrives therefore finishes at the old ratio, and no pulse is ever shortened or doubled.

Top module: `clkdiv_triple`

## Requirements
- R1: After reset the control word reads 0x00100404, and the enable periods are 4 root cycles for bus, 4 for peripheral and 16 for auxiliary.
- R2: The bus divide field is bits [5:0], the peripheral divide field is bits [13:8] and the auxiliary divide field is bits [23:16]. A write stores those bits exactly as given. Every other bit reads 0, whatever was written to it.
- R3: For a field value N in 1..32, the matching enable rises once every N root cycles.
- R4: A field value above 32 gives the same period as 32.
- R5: A field value of 0 behaves like 1, so the enable stays high on every root cycle.
- R6: For a divide above 1, each enable is high for exactly one root cycle per period.
- R7: A new ratio is loaded only at the end of the current period. The period that is running when the write lands keeps the old length, and the following period uses the new one.
- R8: An access is decoded only when the request is high and the address equals the register address. Reads at any other address return 0, and writes there leave the control word unchanged.
- R9: The three dividers are independent. Each one runs only from its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Root clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write strobe, qualified by req_i |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, 0 unless a decoded read |
| bus_en_o | output | 1 | Bus clock enable |
| per_en_o | output | 1 | Peripheral clock enable |
| aux_en_o | output | 1 | Auxiliary clock enable |

## Verification
The hardest case to reach from the ports is a write that lands partway through a running period. In that case the length of that period must come from the old ratio, and only the next period may use the new one. The bench waits for an enable pulse and lets a fixed number of cycles pass. It then writes a new ratio and timestamps the next two pulses, which separates the old length from the new one. Before that, a near-exhaustive sweep of every field over 0..40, plus the top codes, checks the period arithmetic, the clamping and the zero mapping.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NUM_CH = 3;
  // channel order: 0 bus, 1 peripheral, 2 auxiliary
  localparam int CH_LSB [NUM_CH] = '{0, 8, 16};
  localparam int CH_W   [NUM_CH] = '{6, 6, 8};

  function automatic logic [31:0] field_mask();
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int b = 0; b < CH_W[c]; b++)
        m[CH_LSB[c] + b] = 1'b1;
    return m;
  endfunction

  function automatic int norm_div(int raw, int max_div);
    if (raw == 0) return 1;
    if (raw > max_div) return max_div;
    return raw;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int          REG_ADDR = 0,
  parameter logic [31:0] RST_VAL  = 32'h0010_0404,
  parameter logic [31:0] MASK     = 32'h00FF_3F3F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam logic [DATA_W-1:0] MASK_W = DATA_W'(MASK);

  logic [DATA_W-1:0] ctrl_q;
  logic hit, wr;

  assign hit = req_i && (addr_i == ADDR_W'(REG_ADDR));
  assign wr  = hit && we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ctrl_q <= DATA_W'(RST_VAL) & MASK_W;
    else if (wr)  ctrl_q <= wdata_i & MASK_W;
  end

  assign rdata_o = hit ? ctrl_q : '0;
  assign ctrl_o  = ctrl_q;

  p_write_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> ctrl_q == ($past(wdata_i) & MASK_W));
  p_miss_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(ctrl_q));
endmodule

// File: rtl/clkdiv_norm.sv
module clkdiv_norm #(
  parameter int IN_W    = 6,
  parameter int MAX_DIV = 32,
  parameter int CNT_W   = 6
) (
  input  logic [IN_W-1:0]  raw_i,
  output logic [CNT_W-1:0] div_o
);
  always_comb begin
    if (raw_i == '0)                  div_o = CNT_W'(1);
    else if (int'(raw_i) > MAX_DIV)   div_o = CNT_W'(MAX_DIV);
    else                              div_o = CNT_W'(raw_i);
  end

  // R4 R5: effective ratio always legal
  always_comb begin
    a_div_legal_r4: assert (int'(div_o) >= 1 && int'(div_o) <= MAX_DIV);
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int MAX_DIV = 32,
  parameter int CNT_W   = 6,
  parameter int RST_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] div_i,
  output logic             en_o
);
  logic [CNT_W-1:0] cnt_q, cur_q;
  logic wrap;

  assign wrap = (cnt_q == cur_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cur_q <= CNT_W'(RST_DIV);
    end else if (wrap) begin
      cnt_q <= '0;
      cur_q <= div_i;           // ratio changes only at period boundary
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign en_o = (cnt_q == '0);

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < cur_q);
  p_ratio_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q >= CNT_W'(1)) && (int'(cur_q) <= MAX_DIV));
  p_load_at_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> ($past(cnt_q) == $past(cur_q) - CNT_W'(1)));
  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && cur_q > CNT_W'(1)) |=> !en_o);
endmodule

// File: rtl/clkdiv_triple.sv
module clkdiv_triple
  import clkdiv_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter int          REG_ADDR = 0,
  parameter int          MAX_DIV  = 32,
  parameter logic [31:0] RST_VAL  = 32'h0010_0404
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_en_o,
  output logic              per_en_o,
  output logic              aux_en_o
);
  localparam int          CNT_W = $clog2(MAX_DIV + 1);
  localparam logic [31:0] MASK  = field_mask();

  logic [DATA_W-1:0] ctrl;
  logic [NUM_CH-1:0] en;

  clkdiv_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR),
    .RST_VAL(RST_VAL), .MASK(MASK)
  ) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .ctrl_o(ctrl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int RST_RAW = int'((RST_VAL >> CH_LSB[g]) & ((32'd1 << CH_W[g]) - 32'd1));
    logic [CNT_W-1:0] div;

    clkdiv_norm #(.IN_W(CH_W[g]), .MAX_DIV(MAX_DIV), .CNT_W(CNT_W)) u_norm (
      .raw_i(ctrl[CH_LSB[g] +: CH_W[g]]),
      .div_o(div)
    );

    clkdiv_counter #(
      .MAX_DIV(MAX_DIV), .CNT_W(CNT_W), .RST_DIV(norm_div(RST_RAW, MAX_DIV))
    ) u_cnt (
      .clk_i, .rst_ni, .div_i(div), .en_o(en[g])
    );
  end

  assign bus_en_o = en[0];
  assign per_en_o = en[1];
  assign aux_en_o = en[2];

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl & ~DATA_W'(MASK)) == '0);
endmodule

// File: tb/sim_clkdiv_triple.sv
module sim_clkdiv_triple;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        bus_en, per_en, aux_en;
  int errors = 0, checks = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdiv_triple u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .bus_en_o(bus_en), .per_en_o(per_en), .aux_en_o(aux_en)
  );

  function automatic int lsb_of(int ch);
    return ch == 0 ? 0 : (ch == 1 ? 8 : 16);
  endfunction

  function automatic int expect_div(int v);
    if (v == 0) return 1;
    if (v > 32) return 32;
    return v;
  endfunction

  function automatic logic en_of(int ch);
    return ch == 0 ? bus_en : (ch == 1 ? per_en : aux_en);
  endfunction

  task automatic check(string req_tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req_tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0; addr = '0;
  endtask

  task automatic wait_en(int ch);
    do @(negedge clk); while (!en_of(ch));
  endtask

  task automatic gap(int ch, output int n);
    wait_en(ch);
    n = 0;
    do begin @(negedge clk); n++; end while (!en_of(ch));
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    int n, t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1: reset state
    rd(4'd0, d);              check("R1", int'(d), 32'h0010_0404);
    gap(0, n);                check("R1", n, 4);
    gap(1, n);                check("R1", n, 4);
    gap(2, n);                check("R1", n, 16);

    // R2: readback masking
    wr(4'd0, 32'hFFFF_FFFF);  rd(4'd0, d); check("R2", int'(d), 32'h00FF_3F3F);
    wr(4'd0, 32'hA5C3_96E7);  rd(4'd0, d); check("R2", int'(d), 32'h00C3_1627);

    // R8: decode by request and address
    wr(4'd0, 32'h0010_0404);
    wr(4'd1, 32'hFFFF_FFFF);  rd(4'd0, d); check("R8", int'(d), 32'h0010_0404);
    rd(4'd1, d);              check("R8", int'(d), 0);
    @(negedge clk); req = 0; we = 1; addr = 4'd0; wdata = 32'h0003_0303;
    @(negedge clk); we = 0; wdata = '0;
    rd(4'd0, d);              check("R8", int'(d), 32'h0010_0404);
    @(negedge clk); addr = 4'd0; #1 check("R8", int'(rdata), 0);

    // R3 R4 R5 R6: sweep each field, others held at 7
    for (int ch = 0; ch < 3; ch++) begin
      for (int v = 0; v <= 43; v++) begin
        int val = (v <= 40) ? v : (v == 41 ? 63 : (ch == 2 ? (v == 42 ? 200 : 255) : 33));
        logic [31:0] word = 32'h0007_0707;
        word &= ~(32'hFF << lsb_of(ch));
        word |= 32'(val) << lsb_of(ch);
        wr(4'd0, word);
        settle();
        gap(ch, n);
        if (val == 0)      check("R5", n, 1);
        else if (val > 32) check("R4", n, 32);
        else               check("R3", n, expect_div(val));
        if (expect_div(val) > 1) begin
          wait_en(ch); @(negedge clk); check("R6", int'(en_of(ch)), 0);
        end
      end
    end

    // R5: zero keeps enable high continuously
    wr(4'd0, 32'h0000_0000); settle();
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); n += (bus_en & per_en & aux_en); end
    check("R5", n, 20);

    // R9: independent ratios
    wr(4'd0, 32'h0005_0203); settle();
    gap(0, n); check("R9", n, 3);
    gap(1, n); check("R9", n, 2);
    gap(2, n); check("R9", n, 5);

    // R7: write mid-period, 8 -> 3 on bus
    wr(4'd0, 32'h0005_0208); settle();
    wait_en(0); t0 = cyc;
    repeat (2) @(negedge clk);
    wr(4'd0, 32'h0005_0203);
    wait_en(0); t1 = cyc;
    wait_en(0); t2 = cyc;
    check("R7", t1 - t0, 8);
    check("R7", t2 - t1, 3);

    // R7: write mid-period, 20 -> 1 on aux
    wr(4'd0, 32'h0014_0203); settle();
    wait_en(2); t0 = cyc;
    repeat (5) @(negedge clk);
    wr(4'd0, 32'h0001_0203);
    wait_en(2); t1 = cyc;
    @(negedge clk); t2 = cyc;
    check("R7", t1 - t0, 20);
    check("R7", int'(aux_en), 1);
    check("R7", t2 - t1, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule